// File: doc/BRIEF.md
# Lock-Step Network Step Sequencer

This block is the control core of an accelerator for a fully connected neuron network that runs in lock-step. The host loads three run parameters: the network size N, the number of simulation steps and the unroll factor U. It then pulses start. From that point the sequencer runs the whole simulation without the host. In each step it walks every neuron in ascending order. For each neuron it walks all N neighbours in groups of U, issuing one group per clock with no bubbles. Each issue carries the neuron index, the base index of the neighbour group, and strobes that tell the datapath when to pull a stimulus value or the first-step initial state from the input stream.

The arithmetic datapath is modelled as a valid pipe with a fixed latency of PIPE_LAT cycles. The issue of a neuron's final group travels through this pipe and comes out as a write-back strobe with the state-memory address. The same strobe marks the cycle in which that neuron's output voltage goes to the output stream. A step never overlaps the next one. After the last issue of a step, the sequencer waits PIPE_LAT cycles so that the pipe drains, pulses step-done, and only then starts the next step. A configuration in which U does not divide N, or in which any parameter is zero, is rejected with an error flag.

Top module: `lockstep_sequencer`

## Requirements
- R1: While reset is held and after it is released, busy, done, cfg_err, iss_valid, wb_valid and step_done are all 0, and step_idx is 0.
- R2: A start received while idle is refused when N is 0, U is 0, the step count is 0, or N mod U is not 0. A refused start sets cfg_err to 1 from the next cycle, and busy and iss_valid stay 0. An accepted start clears cfg_err from the next cycle.
- R3: In the cycle after an accepted start, issue begins with neuron 0 and neighbour base 0. Each following cycle advances the neighbour base by U. When the base reaches N-U (iss_last = 1), the next cycle moves to the next neuron at base 0. This continues back-to-back through neuron N-1.
- R4: One step has exactly N*N/U issue cycles. A run has exactly steps*N*N/U issue cycles in total.
- R5: After the last issue of a step, iss_valid stays 0 for exactly PIPE_LAT cycles. step_done is 1 in the last of those cycles only. The next step's first issue follows in the cycle after step_done.
- R6: stim_take is 1 on the first group (base 0) of every neuron in every step. init_load is 1 on the first group of every neuron in step 0 only.
- R7: wb_valid is 1 exactly PIPE_LAT cycles after each issue with iss_last = 1, with wb_addr equal to that issue's neuron. This gives one write-back per neuron per step, in ascending neuron order.
- R8: busy is 1 from the cycle after an accepted start through the final step_done cycle. done is 1 for the single following cycle, with busy 0.
- R9: step_idx equals the number of steps completed in the run. It counts up in the cycle after each non-final step_done and is 0 again from the done cycle onward.
- R10: A start pulse, or any change of the cfg inputs, while busy has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| cfg_n | input | IDX_W | Network size N |
| cfg_unroll | input | IDX_W | Neighbours per issue, U |
| cfg_steps | input | STEP_W | Number of simulation steps |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start was refused |
| iss_valid | output | 1 | A neighbour group is issued this cycle |
| iss_neuron | output | IDX_W | Neuron being computed; own-state read address |
| iss_nbr_base | output | IDX_W | First neighbour of the group; neighbour-state read base |
| iss_last | output | 1 | Final group of the current neuron |
| stim_take | output | 1 | Pull one stimulus value from the input stream |
| init_load | output | 1 | Pull initial state and influence from the input stream |
| wb_valid | output | 1 | State write-back and output-voltage emit strobe |
| wb_addr | output | IDX_W | State-memory write address |
| step_done | output | 1 | Pipe drained, step finished |
| step_idx | output | STEP_W | Steps completed in this run |

## Verification
The issue strobes and indices change in the cycle after the clock edge that accepts start, because the state register is the only register on that path. A write-back is due PIPE_LAT cycles after the issue of a neuron's final group. step_done falls in the last cycle of a PIPE_LAT-long gap, and done comes one cycle after the final step_done. The bench derives all of these from a closed-form timeline indexed by the cycle count since start. It compares every output against that timeline at each falling edge, so each result is checked in exactly the cycle it is due, and it tallies the issue cycles against steps*N*N/U.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lss_cfg_check.sv
module lss_cfg_check #(
  parameter int IDX_W  = 6,
  parameter int STEP_W = 16
) (
  input  logic [IDX_W-1:0]  n_in,
  input  logic [IDX_W-1:0]  u_in,
  input  logic [STEP_W-1:0] steps_in,
  output logic              ok,
  output logic [IDX_W-1:0]  groups
);
  logic nonzero;

  always_comb begin
    nonzero = (n_in != '0) && (u_in != '0) && (steps_in != '0);
    ok      = 1'b0;
    groups  = '0;
    if (nonzero) begin
      ok = ((n_in % u_in) == '0);
      if (ok) groups = n_in / u_in;
    end
  end
endmodule

// File: rtl/lss_loop_counters.sv
module lss_loop_counters #(
  parameter int IDX_W  = 6,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              step_adv,
  input  logic [IDX_W-1:0]  u_cfg,
  input  logic [IDX_W-1:0]  n_last,
  input  logic [IDX_W-1:0]  g_last,
  output logic [IDX_W-1:0]  grp,
  output logic [IDX_W-1:0]  nrn,
  output logic [IDX_W-1:0]  base,
  output logic [STEP_W-1:0] stp,
  output logic              last_grp,
  output logic              last_nrn
);
  logic [IDX_W-1:0]  grp_q, grp_d, nrn_q, nrn_d, base_q, base_d;
  logic [STEP_W-1:0] stp_q, stp_d;
  logic              cnt_en;

  always_comb begin
    last_grp = (grp_q == g_last);
    last_nrn = (nrn_q == n_last);
    cnt_en   = clr | adv | step_adv;
    grp_d    = grp_q;
    nrn_d    = nrn_q;
    base_d   = base_q;
    stp_d    = stp_q;
    if (clr) begin
      grp_d  = '0;
      nrn_d  = '0;
      base_d = '0;
      stp_d  = '0;
    end else begin
      if (adv) begin
        if (last_grp) begin
          grp_d  = '0;
          base_d = '0;
          nrn_d  = last_nrn ? '0 : nrn_q + 1'b1;
        end else begin
          grp_d  = grp_q + 1'b1;
          base_d = base_q + u_cfg;
        end
      end
      if (step_adv) stp_d = stp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      nrn_q  <= '0;
      base_q <= '0;
      stp_q  <= '0;
    end else if (cnt_en) begin
      grp_q  <= grp_d;
      nrn_q  <= nrn_d;
      base_q <= base_d;
      stp_q  <= stp_d;
    end
  end

  assign grp  = grp_q;
  assign nrn  = nrn_q;
  assign base = base_q;
  assign stp  = stp_q;

  // R3
  base_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (base_q <= n_last));

  // R4
  grp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (grp_q <= g_last));
endmodule

// File: rtl/lss_valid_pipe.sv
module lss_valid_pipe #(
  parameter int LAT = 4,
  parameter int W   = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat,
  output logic         pending
);
  logic [LAT-1:0] v_q;
  logic [W-1:0]   d_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    logic         v_src;
    logic [W-1:0] d_src;
    if (i == 0) begin : g_head
      assign v_src = in_vld;
      assign d_src = in_dat;
    end else begin : g_body
      assign v_src = v_q[i-1];
      assign d_src = d_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[i] <= 1'b0;
      else        v_q[i] <= v_src;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     d_q[i] <= '0;
      else if (v_src) d_q[i] <= d_src;
    end
  end

  always_comb begin
    pending = 1'b0;
    for (int i = 0; i < LAT - 1; i++) pending = pending | v_q[i];
  end

  assign out_vld = v_q[LAT-1];
  assign out_dat = d_q[LAT-1];
endmodule

// File: rtl/lockstep_sequencer.sv
module lockstep_sequencer
  import lss_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int STEP_W   = 16,
  parameter int PIPE_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cfg_n,
  input  logic [IDX_W-1:0]  cfg_unroll,
  input  logic [STEP_W-1:0] cfg_steps,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              iss_valid,
  output logic [IDX_W-1:0]  iss_neuron,
  output logic [IDX_W-1:0]  iss_nbr_base,
  output logic              iss_last,
  output logic              stim_take,
  output logic              init_load,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_addr,
  output logic              step_done,
  output logic [STEP_W-1:0] step_idx
);
  localparam int FL_W = (PIPE_LAT < 2) ? 1 : $clog2(PIPE_LAT);
  localparam logic [FL_W-1:0] FL_END = FL_W'(PIPE_LAT - 1);

  seq_state_e        state_q, state_d;
  logic [FL_W-1:0]   fl_q, fl_d;
  logic [IDX_W-1:0]  n_r, u_r, g_r;
  logic [STEP_W-1:0] steps_r;
  logic              err_q, err_d;
  logic              cfg_ok, accept, cnt_clr, last_step, pipe_pending;
  logic [IDX_W-1:0]  groups, grp, nrn, base;
  logic [STEP_W-1:0] stp;
  logic              last_grp, last_nrn;

  lss_cfg_check #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_cfg (
    .n_in(cfg_n), .u_in(cfg_unroll), .steps_in(cfg_steps),
    .ok(cfg_ok), .groups(groups)
  );

  always_comb begin
    accept    = (state_q == ST_IDLE) && start && cfg_ok;
    iss_valid = (state_q == ST_ISSUE);
    step_done = (state_q == ST_FLUSH) && (fl_q == FL_END);
    last_step = (stp == steps_r - STEP_W'(1));
    cnt_clr   = accept || (step_done && last_step);
    state_d   = state_q;
    fl_d      = fl_q;
    err_d     = err_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          err_d = !cfg_ok;
          if (cfg_ok) state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (last_grp && last_nrn) begin
          state_d = ST_FLUSH;
          fl_d    = '0;
        end
      end
      ST_FLUSH: begin
        fl_d = fl_q + 1'b1;
        if (fl_q == FL_END) state_d = last_step ? ST_DONE : ST_ISSUE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fl_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fl_q    <= fl_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_r     <= '0;
      u_r     <= '0;
      g_r     <= '0;
      steps_r <= '0;
    end else if (accept) begin
      n_r     <= cfg_n;
      u_r     <= cfg_unroll;
      g_r     <= groups - 1'b1;
      steps_r <= cfg_steps;
    end
  end

  lss_loop_counters #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(iss_valid),
    .step_adv(step_done), .u_cfg(u_r), .n_last(n_r - 1'b1), .g_last(g_r),
    .grp(grp), .nrn(nrn), .base(base), .stp(stp),
    .last_grp(last_grp), .last_nrn(last_nrn)
  );

  lss_valid_pipe #(.LAT(PIPE_LAT), .W(IDX_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(iss_valid && last_grp), .in_dat(nrn),
    .out_vld(wb_valid), .out_dat(wb_addr), .pending(pipe_pending)
  );

  assign busy         = (state_q == ST_ISSUE) || (state_q == ST_FLUSH);
  assign done         = (state_q == ST_DONE);
  assign cfg_err      = err_q;
  assign iss_neuron   = nrn;
  assign iss_nbr_base = base;
  assign iss_last     = iss_valid && last_grp;
  assign stim_take    = iss_valid && (grp == '0);
  assign init_load    = iss_valid && (grp == '0) && (stp == '0);
  assign step_idx     = stp;

  // R5
  flush_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (!pipe_pending && !iss_valid));

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R2
  err_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !busy);

  // R7
  wb_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_addr < n_r));

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(n_r) && $stable(u_r) && $stable(steps_r)));
endmodule

// File: tb/lockstep_sequencer_bench.sv
`timescale 1ns/1ps
module lockstep_sequencer_bench;
  localparam int IDX_W = 6;
  localparam int STEP_W = 16;
  localparam int LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IDX_W-1:0] cfg_n = '0, cfg_unroll = '0;
  logic [STEP_W-1:0] cfg_steps = '0;
  logic busy, done, cfg_err, iss_valid, iss_last, stim_take, init_load;
  logic wb_valid, step_done;
  logic [IDX_W-1:0] iss_neuron, iss_nbr_base, wb_addr;
  logic [STEP_W-1:0] step_idx;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  lockstep_sequencer #(.IDX_W(IDX_W), .STEP_W(STEP_W), .PIPE_LAT(LAT)) u_lockstep_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_n(cfg_n), .cfg_unroll(cfg_unroll),
    .cfg_steps(cfg_steps), .busy(busy), .done(done), .cfg_err(cfg_err),
    .iss_valid(iss_valid), .iss_neuron(iss_neuron), .iss_nbr_base(iss_nbr_base),
    .iss_last(iss_last), .stim_take(stim_take), .init_load(init_load),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .step_done(step_done), .step_idx(step_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Closed-form issue word: {valid, neuron, base, last}
  function automatic int exp_issue(int n, int u, int o);
    int g = n / u;
    if (o >= n * g) return 0;
    return (1 << 20) | ((o / g) << 12) | (((o % g) * u) << 4) | (((o % g) == g - 1) ? 1 : 0);
  endfunction

  function automatic int exp_wb(int n, int u, int o);
    int g = n / u;
    int r = o - LAT;
    if (r < 0 || r >= n * g) return 0;
    if ((r % g) != g - 1) return 0;
    return (1 << 8) | (r / g);
  endfunction

  task automatic run(input int n, input int u, input int s, input bit poke);
    int g = n / u;
    int len = n * g + LAT;
    int tot = s * len;
    int issues = 0;
    @(negedge clk);
    cfg_n = IDX_W'(n); cfg_unroll = IDX_W'(u); cfg_steps = STEP_W'(s); start = 1'b1;
    for (int c = 1; c <= tot + 3; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && c == 3) begin
        start = 1'b1; cfg_n = 6'd7; cfg_unroll = 6'd3; cfg_steps = 16'd9;
      end
      if (c <= tot) begin
        int k = (c - 1) / len;
        int o = (c - 1) % len;
        int ei = exp_issue(n, u, o);
        int ai = (iss_valid ? (1 << 20) | (int'(iss_neuron) << 12) |
                  (int'(iss_nbr_base) << 4) | (iss_last ? 1 : 0) : 0);
        int ew = exp_wb(n, u, o);
        int aw = wb_valid ? (1 << 8) | int'(wb_addr) : 0;
        bit fs = (ei != 0) && ((o % g) == 0);
        if (iss_valid) issues++;
        chk(ai == ei, poke ? "R3/R10 issue" : "R3 issue", ai, ei);
        chk(stim_take == fs, "R6 stim_take", stim_take, fs);
        chk(init_load == (fs && k == 0), "R6 init_load", init_load, fs && k == 0);
        chk(aw == ew, "R7 writeback", aw, ew);
        chk(step_done == (o == len - 1), "R5 step_done", step_done, o == len - 1);
        chk(busy && !done, "R8 busy", {busy, done}, 2);
        chk(int'(step_idx) == k, "R9 step_idx", step_idx, k);
        chk(!cfg_err, "R2 cfg_err clear", cfg_err, 0);
      end else if (c == tot + 1) begin
        chk(done && !busy, "R8 done pulse", {busy, done}, 1);
        chk(step_idx == '0, "R9 step_idx cleared", step_idx, 0);
      end else begin
        chk(!done && !busy && !iss_valid && !wb_valid, "R8 idle after done",
            {busy, done, iss_valid, wb_valid}, 0);
      end
    end
    chk(issues == s * n * g, "R4 total issue count", issues, s * n * g);
  endtask

  task automatic bad_cfg(input int n, input int u, input int s);
    @(negedge clk);
    cfg_n = IDX_W'(n); cfg_unroll = IDX_W'(u); cfg_steps = STEP_W'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 4; c++) begin
      chk(cfg_err && !busy && !iss_valid, "R2 refused start",
          {cfg_err, busy, iss_valid}, 4);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed, n, u, s;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cfg_err && !iss_valid && !wb_valid && !step_done && step_idx == 0,
        "R1 reset held", {busy, done, cfg_err, iss_valid, wb_valid, step_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !cfg_err && !iss_valid && !wb_valid && !step_done && step_idx == 0,
        "R1 after reset", {busy, done, cfg_err, iss_valid, wb_valid, step_done}, 0);

    run(1, 1, 1, 1'b0);
    run(4, 4, 2, 1'b0);
    run(6, 2, 3, 1'b1);
    run(5, 1, 1, 1'b0);
    bad_cfg(4, 0, 1);
    bad_cfg(0, 1, 1);
    bad_cfg(6, 4, 1);
    bad_cfg(4, 2, 0);
    bad_cfg(2, 4, 1);
    run(8, 2, 2, 1'b0);
    for (int i = 0; i < 10; i++) begin
      n = 1 + int'($urandom % 12);
      u = 1 + int'($urandom % n);
      while ((n % u) != 0) u--;
      s = 1 + int'($urandom % 3);
      run(n, u, s, (i % 3) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule